// File: doc/BRIEF.md
# Command Ring Start, Stop and Abort Controller

This block holds the control register of a host controller's command ring and runs the small state machine that starts, drains and kills ring execution. Software loads a 64-bit ring base as two dword writes, low half first, and then rings a doorbell to start the ring. While the ring runs, software can request a graceful stop, which lets the current command finish, or an abort, which kills it at once.

A simple handshake stands in for the command engine. The block raises a go level while the engine may fetch and execute commands. It raises a one-cycle kill pulse on abort. The engine returns an idle level that marks the end of its current command, and a flip strobe when it crosses a ring wrap that toggles the consumer cycle state. When the ring comes to rest, the block emits a one-cycle completion event with an 8-bit code. A stop and an abort each report their own code.

Top module: `cmd_ring_ctrl`

## Requirements
- R1: After reset the ring is halted. `ring_running`, `eng_go`, `eng_kill` and `evt_valid` are 0, and both read dwords and `ring_base` are 0.
- R2: A low-dword write (`wr_hi`=0) while halted loads the cycle state from bit 0, the reserved pair from bits 5:4 and base bits 31:6 from the same bits. `ring_base[5:0]` is always 0. The low readback is {base[31:6], bits 5:4, running at bit 3, 0 at bits 2:1, cycle at bit 0}.
- R3: A high-dword write (`wr_hi`=1) while halted loads `ring_base[63:32]` and leaves the low half untouched. The high readback returns it.
- R4: A `db_ring` pulse while halted sets `ring_running` and `eng_go` on the next cycle, and read bit 3 becomes 1.
- R5: While running, low- and high-dword writes leave the base, the reserved pair and the cycle state unchanged.
- R6: A low-dword write with bit 1 set while running drops `eng_go` on the next cycle. The ring stays running until `eng_idle` is sampled high. On that edge `ring_running` clears and `evt_valid` rises with code 24.
- R7: A low-dword write with bit 2 set while running pulses `eng_kill` for the next cycle, without waiting for `eng_idle`. On the following edge the ring halts and `evt_valid` rises with code 25.
- R8: When bits 1 and 2 are set in the same write, the abort path of R7 is taken and the code is 25.
- R9: Stop and abort bits written while halted cause no event and leave the ring halted.
- R10: An `eng_cyc_flip` pulse while running inverts the cycle state. While halted it has no effect.
- R11: `evt_valid` is high for exactly one cycle per halt.
- R12: An abort written while a stop is draining overrides it and reports code 25.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_hi | input | 1 | Selects the high dword (1) or the low control dword (0) for a write |
| wr_data | input | 32 | Write data |
| rd_hi | input | 1 | Selects the high dword (1) or the low control dword (0) for readback |
| rd_data | output | 32 | Readback data |
| db_ring | input | 1 | Doorbell start strobe |
| eng_go | output | 1 | Engine may fetch and execute commands |
| eng_kill | output | 1 | One-cycle abort of the executing command |
| eng_idle | input | 1 | Engine has no command in progress |
| eng_cyc_flip | input | 1 | Engine crossed a ring wrap; toggle the consumer cycle state |
| ring_base | output | 64 | Ring base address, 64-byte aligned |
| ring_cyc | output | 1 | Consumer cycle state |
| ring_running | output | 1 | Ring running flag |
| evt_valid | output | 1 | Completion event pulse |
| evt_code | output | 8 | Completion code, valid with evt_valid |

## Verification
The bench holds `eng_idle` low across a stop to prove that the stop drains. A design that halted at once would drop `ring_running` early and post code 24 before the engine is idle. It aborts with the engine busy, and with both request bits set together, to catch a design that waits for idle on abort or lets stop win and reports 24. It writes the base and cycle while running, and flips the cycle while halted, to expose missing write guards. It also writes request bits while halted, where a careless decoder would post a spurious event.

// File: rtl/cmd_ring_ctrl.sv
module cmd_ring_ctrl #(
  parameter int DW         = 32,
  parameter int ALIGN      = 6,
  parameter int CODE_W     = 8,
  parameter int STOP_CODE  = 24,
  parameter int ABORT_CODE = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_hi,
  output logic [DW-1:0]     rd_data,
  input  logic              db_ring,
  output logic              eng_go,
  output logic              eng_kill,
  input  logic              eng_idle,
  input  logic              eng_cyc_flip,
  output logic [2*DW-1:0]   ring_base,
  output logic              ring_cyc,
  output logic              ring_running,
  output logic              evt_valid,
  output logic [CODE_W-1:0] evt_code
);
  localparam int RSV_LO = 4;
  localparam logic [CODE_W-1:0] C_STOP  = CODE_W'(STOP_CODE);
  localparam logic [CODE_W-1:0] C_ABORT = CODE_W'(ABORT_CODE);

  typedef enum logic [1:0] {S_HALT, S_RUN, S_STOP, S_ABORT} st_t;
  st_t st, st_nx;

  logic [DW-1:ALIGN]     base_lo;
  logic [ALIGN-1:RSV_LO] rsv;
  logic [DW-1:0]         base_hi;
  logic                  cyc;

  wire wr_lo     = wr_en & ~wr_hi;
  wire wr_up     = wr_en & wr_hi;
  wire req_stop  = wr_lo & wr_data[1];
  wire req_abort = wr_lo & wr_data[2];
  wire halted    = (st == S_HALT);

  always_comb begin
    st_nx = st;
    unique case (st)
      S_HALT:  if (db_ring) st_nx = S_RUN;
      S_RUN:   if (req_abort) st_nx = S_ABORT;
               else if (req_stop) st_nx = S_STOP;
      S_STOP:  if (req_abort) st_nx = S_ABORT;
               else if (eng_idle) st_nx = S_HALT;
      S_ABORT: st_nx = S_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_HALT;
      evt_valid <= 1'b0;
      evt_code  <= '0;
    end else begin
      st        <= st_nx;
      evt_valid <= (st == S_ABORT) || (st == S_STOP && st_nx == S_HALT);
      evt_code  <= (st == S_ABORT) ? C_ABORT : C_STOP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_lo <= '0;
      rsv     <= '0;
      base_hi <= '0;
      cyc     <= 1'b0;
    end else if (halted) begin
      if (wr_lo) begin
        base_lo <= wr_data[DW-1:ALIGN];
        rsv     <= wr_data[ALIGN-1:RSV_LO];
        cyc     <= wr_data[0];
      end
      if (wr_up) base_hi <= wr_data;
    end else if (eng_cyc_flip) begin
      cyc <= ~cyc;
    end
  end

  assign ring_running = ~halted;
  assign eng_go       = (st == S_RUN);
  assign eng_kill     = (st == S_ABORT);
  assign ring_cyc     = cyc;
  assign ring_base    = {base_hi, base_lo, {ALIGN{1'b0}}};
  assign rd_data      = rd_hi ? base_hi
                              : {base_lo, rsv, ring_running, 2'b00, cyc};

  AST_GO_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go |-> ring_running); // R4
  AST_BASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_running && $past(ring_running)) |-> $stable(ring_base)); // R5
  AST_HALT_POSTS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ring_running) |-> evt_valid); // R6
  AST_STOP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && $past(st == S_STOP)) |-> evt_code == C_STOP); // R6
  AST_KILL_THEN_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    eng_kill |=> (!eng_kill && !ring_running && evt_code == C_ABORT)); // R7
  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> !evt_valid); // R11
endmodule

// File: tb/sim_cmd_ring_ctrl.sv
module sim_cmd_ring_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, wr_hi = 0, rd_hi = 0, db_ring = 0;
  logic        eng_idle = 0, eng_cyc_flip = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic        eng_go, eng_kill, ring_cyc, ring_running, evt_valid;
  logic [63:0] ring_base;
  logic [7:0]  evt_code;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_ring_ctrl u0 (.clk, .rst_n, .wr_en, .wr_hi, .wr_data, .rd_hi, .rd_data,
    .db_ring, .eng_go, .eng_kill, .eng_idle, .eng_cyc_flip, .ring_base,
    .ring_cyc, .ring_running, .evt_valid, .evt_code);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic wr(logic hi, logic [31:0] d);
    wr_en = 1; wr_hi = hi; wr_data = d; tick(); wr_en = 0; wr_data = 0;
  endtask

  task automatic rd_lo(output logic [31:0] v); rd_hi = 0; #1 v = rd_data; endtask
  task automatic rd_up(output logic [31:0] v); rd_hi = 1; #1 v = rd_data; rd_hi = 0; endtask

  task automatic start();
    db_ring = 1; tick(); db_ring = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd_lo(v); chk("R1 lo", v, 0);
    rd_up(v); chk("R1 hi", v, 0);
    chk("R1 flags", {ring_running, eng_go, eng_kill, evt_valid}, 0);
    chk("R1 base", ring_base, 0);
  endtask

  task automatic t_ptr();
    logic [31:0] v;
    wr(0, 32'hDEAD_BEFF);
    rd_lo(v); chk("R2 lo readback", v, 32'hDEAD_BEF1);
    chk("R2 base aligned", ring_base, 64'h0000_0000_DEAD_BEC0);
    chk("R2 cycle", ring_cyc, 1);
    wr(1, 32'h1234_5678);
    rd_up(v); chk("R3 hi readback", v, 32'h1234_5678);
    chk("R3 base", ring_base, 64'h1234_5678_DEAD_BEC0);
  endtask

  task automatic t_halted_req();
    wr(0, 32'hDEAD_BEF7);
    for (int i = 0; i < 3; i++) begin
      chk("R9 no event", evt_valid, 0);
      chk("R9 halted", ring_running, 0);
      tick();
    end
    chk("R9 base kept", ring_base, 64'h1234_5678_DEAD_BEC0);
  endtask

  task automatic t_flip_halted();
    eng_cyc_flip = 1; tick(); eng_cyc_flip = 0;
    chk("R10 halted flip ignored", ring_cyc, 1);
  endtask

  task automatic t_start_and_guard();
    logic [31:0] v;
    start();
    chk("R4 running", ring_running, 1);
    chk("R4 go", eng_go, 1);
    rd_lo(v); chk("R4 read bit3", v[3], 1);
    wr(0, 32'h0000_0000);
    wr(1, 32'h0000_0000);
    chk("R5 base kept", ring_base, 64'h1234_5678_DEAD_BEC0);
    chk("R5 cycle kept", ring_cyc, 1);
    rd_lo(v); chk("R5 reserved kept", v[5:4], 2'b11);
    eng_cyc_flip = 1; tick(); eng_cyc_flip = 0;
    chk("R10 flip", ring_cyc, 0);
  endtask

  task automatic t_stop();
    eng_idle = 0;
    wr(0, 32'h2);
    chk("R6 go dropped", eng_go, 0);
    chk("R6 still running", ring_running, 1);
    tick(); tick();
    chk("R6 waits idle", ring_running, 1);
    chk("R6 no early evt", evt_valid, 0);
    eng_idle = 1; tick();
    chk("R6 halted", ring_running, 0);
    chk("R6 evt", evt_valid, 1);
    chk("R6 code", evt_code, 24);
    eng_idle = 0; tick();
    chk("R11 pulse ends", evt_valid, 0);
  endtask

  task automatic t_abort(string req, logic [31:0] d);
    start();
    eng_idle = 0;
    wr(0, d);
    chk({req, " kill"}, eng_kill, 1);
    tick();
    chk({req, " halted"}, ring_running, 0);
    chk({req, " evt"}, evt_valid, 1);
    chk({req, " code"}, evt_code, 25);
    chk({req, " kill ends"}, eng_kill, 0);
    tick();
    chk("R11 abort pulse ends", evt_valid, 0);
  endtask

  task automatic t_stop_then_abort();
    start();
    eng_idle = 0;
    wr(0, 32'h2);
    tick();
    wr(0, 32'h4);
    chk("R12 kill", eng_kill, 1);
    tick();
    chk("R12 halted", ring_running, 0);
    chk("R12 code", evt_code, 25);
    chk("R12 evt", evt_valid, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ptr();
    t_halted_req();
    t_flip_halted();
    t_start_and_guard();
    t_stop();
    t_abort("R7", 32'h4);
    t_abort("R8", 32'h6);
    t_stop_then_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule